// File: doc/BRIEF.md
# Interval Hint Recorder

This per-core block closes recording intervals and, at each closing, emits one hint record. A record holds two values taken in the same cycle: the core's count of committed memory operations and the number of stores that have committed but still sit in its store buffer. Because every core closes its interval at the same cycle, the records form a cut across all cores that offline tools can treat as a barrier.

A two-bit mode input selects what closes an interval. The first option is a fixed number of clock cycles. The second is a number of coherence broadcasts snooped on the bus, counted by each core with no traffic to other cores. The third is a number of local downgrades or invalidations, where the core that crosses its limit raises a request that every core (itself included) answers with a hint in the same cycle. The fourth combines the downgrade trigger with the cycle limit, and whichever fires first closes the interval. The limits are inputs, so the interval length can track how much the cores talk to each other.

Top module: `hint_recorder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hintValid` and `barrierReqOut` are 0 and all trigger counters are cleared.
- R2: In cycle mode (`trigMode` = 0) a hint is emitted every `cycleLimit` cycles: the first `hintValid` pulse is seen `cycleLimit` clock edges after reset release, and then again every `cycleLimit` edges (a limit of 0 acts as 1).
- R3: In broadcast mode (`trigMode` = 1) the snoop pulse that takes the count past `snoopLimit` (pulse number `snoopLimit`+1 since the last hint) gives `hintValid` on the next edge; `barrierReqOut` stays 0 in this mode.
- R4: In downgrade mode (`trigMode` = 2) the downgrade pulse that takes the count past `downLimit` raises `barrierReqOut` for exactly one cycle on the next edge, and `hintValid` follows one edge after that.
- R5: In modes 2 and 3 a high `barrierReqIn` produces a hint on the next edge and clears the downgrade count.
- R6: In modes 0 and 1 `barrierReqIn` has no effect; in modes 1 and 2 the cycle limit has no effect.
- R7: `hintCommit` equals `commitCount` in the cycle in which the interval closed.
- R8: `hintPending` is one bit wider than needed to count store-buffer entries minus one, so a full buffer (32 for the default depth) is reported as 32 and never wraps to 0.
- R9: In mode 3 the cycle limit and the downgrade trigger both close the interval; whichever closes it first clears both counts.
- R10: A local downgrade trigger and `barrierReqIn` in the same cycle give one hint and no `barrierReqOut`.
- R11: Any interval closing clears every count; a trigger pulse arriving in the closing cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trigMode | input | 2 | 0 cycles, 1 broadcasts, 2 downgrades, 3 downgrades or cycles |
| cycleLimit | input | LIMIT_W | Cycles per interval |
| snoopLimit | input | LIMIT_W | Snooped broadcasts tolerated before closing |
| downLimit | input | LIMIT_W | Downgrades tolerated before requesting a barrier |
| commitCount | input | CNT_W | Committed memory operation count |
| sbOccupancy | input | OCC_W | Committed stores not yet performed |
| snoopPulse | input | 1 | One snooped coherence broadcast this cycle |
| downPulse | input | 1 | One downgrade or invalidation this cycle |
| barrierReqIn | input | 1 | OR of the other cores' barrier requests |
| barrierReqOut | output | 1 | Barrier request to the other cores |
| hintValid | output | 1 | Hint record valid this cycle |
| hintCommit | output | CNT_W | Committed count of the record |
| hintPending | output | OCC_W | Pending store count of the record |

## Verification
The bench sweeps every small limit in each mode and predicts hint cycles arithmetically, so an off-by-one in a comparison shifts a pulse and is caught; a recorder that counted "reaches" instead of "exceeds" for broadcasts would close one snoop early. It drives a full store buffer, where a field of the minimum width would report 0. It sends a remote request together with a local trigger, where a design without suppression would emit two hints or a stray request, and sends a downgrade pulse inside the closing cycle and across a cycle-limit close in combined mode, where a design that kept stale counts would request a barrier too early.

// File: rtl/hint_rec_pkg.sv
package hint_rec_pkg;

  typedef enum logic [1:0] {
    MODE_CYCLE      = 2'd0,
    MODE_SNOOP      = 2'd1,
    MODE_DOWN       = 2'd2,
    MODE_DOWN_CYCLE = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic capture;   // close interval and latch a record
    logic clearCnt;  // clear all trigger counters
  } hint_strobe_t;

endpackage

// File: rtl/hint_rec_ctrl.sv
module hint_rec_ctrl
  import hint_rec_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         trigMode,
  input  logic [LIMIT_W-1:0] cycleLimit,
  input  logic [LIMIT_W-1:0] snoopLimit,
  input  logic [LIMIT_W-1:0] downLimit,
  input  logic               snoopPulse,
  input  logic               downPulse,
  input  logic               barrierReqIn,
  output logic               barrierReqOut,
  output hint_strobe_t       strobe
);

  localparam int EXT_W = LIMIT_W + 1;

  trig_mode_e modeSel;
  assign modeSel = trig_mode_e'(trigMode);

  logic [LIMIT_W-1:0] cycCnt, snCnt, dnCnt;
  logic cycOn, snoopOn, downOn;
  logic cycReach, snReach, barrierHit, closeNow, localDown;

  always_comb begin
    cycOn   = (modeSel == MODE_CYCLE) || (modeSel == MODE_DOWN_CYCLE);
    snoopOn = (modeSel == MODE_SNOOP);
    downOn  = (modeSel == MODE_DOWN) || (modeSel == MODE_DOWN_CYCLE);
  end

  // Closing conditions
  always_comb begin
    cycReach   = cycOn && ((EXT_W'(cycCnt) + EXT_W'(1)) >= EXT_W'(cycleLimit));
    snReach    = snoopOn && snoopPulse && (snCnt >= snoopLimit);
    // Own pending request is always honoured; remote only in downgrade modes.
    barrierHit = barrierReqOut || (downOn && barrierReqIn);
    closeNow   = cycReach || snReach || barrierHit;
    // A local trigger is dropped when this cycle already closes the interval.
    localDown  = downOn && downPulse && (dnCnt >= downLimit) && !closeNow;
  end

  always_comb begin
    strobe.capture  = closeNow;
    strobe.clearCnt = closeNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycCnt        <= '0;
      snCnt         <= '0;
      dnCnt         <= '0;
      barrierReqOut <= 1'b0;
    end else if (strobe.clearCnt) begin
      cycCnt        <= '0;
      snCnt         <= '0;
      dnCnt         <= '0;
      barrierReqOut <= 1'b0;
    end else begin
      barrierReqOut <= localDown;
      if (cycOn) cycCnt <= cycCnt + 1'b1;
      if (snoopOn && snoopPulse) snCnt <= snCnt + 1'b1;
      if (localDown) dnCnt <= '0;
      else if (downOn && downPulse) dnCnt <= dnCnt + 1'b1;
    end
  end

  // R4: a barrier request lasts exactly one cycle
  a_r4_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    barrierReqOut |=> !barrierReqOut);

  // R10: a remote request never leads to a local request on the next edge
  a_r10_no_double: assert property (@(posedge clk) disable iff (!rst_n)
    barrierReqIn |=> !barrierReqOut);

  // R3/R6: no request is raised out of the non-downgrade modes
  a_r3_no_req_local_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (trigMode[1] == 1'b0) |=> !barrierReqOut);

endmodule

// File: rtl/hint_rec_datapath.sv
module hint_rec_datapath
  import hint_rec_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int OCC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hint_strobe_t     strobe,
  input  logic [CNT_W-1:0] commitCount,
  input  logic [OCC_W-1:0] sbOccupancy,
  output logic             hintValid,
  output logic [CNT_W-1:0] hintCommit,
  output logic [OCC_W-1:0] hintPending
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hintValid   <= 1'b0;
      hintCommit  <= '0;
      hintPending <= '0;
    end else begin
      hintValid <= strobe.capture;
      if (strobe.capture) begin
        hintCommit  <= commitCount;
        hintPending <= sbOccupancy;
      end
    end
  end

  // R7: record carries the commit count of the closing cycle
  a_r7_commit_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    hintValid |-> (hintCommit == $past(commitCount)));

  // R8: record carries the occupancy of the closing cycle, full width
  a_r8_occ_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    hintValid |-> (hintPending == $past(sbOccupancy)));

endmodule

// File: rtl/hint_recorder.sv
module hint_recorder
  import hint_rec_pkg::*;
#(
  parameter int LIMIT_W  = 16,
  parameter int CNT_W    = 32,
  parameter int SB_DEPTH = 32,
  parameter int OCC_W    = $clog2(SB_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         trigMode,
  input  logic [LIMIT_W-1:0] cycleLimit,
  input  logic [LIMIT_W-1:0] snoopLimit,
  input  logic [LIMIT_W-1:0] downLimit,
  input  logic [CNT_W-1:0]   commitCount,
  input  logic [OCC_W-1:0]   sbOccupancy,
  input  logic               snoopPulse,
  input  logic               downPulse,
  input  logic               barrierReqIn,
  output logic               barrierReqOut,
  output logic               hintValid,
  output logic [CNT_W-1:0]   hintCommit,
  output logic [OCC_W-1:0]   hintPending
);

  hint_strobe_t strobe;

  hint_rec_ctrl #(.LIMIT_W(LIMIT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .trigMode(trigMode),
    .cycleLimit(cycleLimit), .snoopLimit(snoopLimit), .downLimit(downLimit),
    .snoopPulse(snoopPulse), .downPulse(downPulse),
    .barrierReqIn(barrierReqIn), .barrierReqOut(barrierReqOut),
    .strobe(strobe)
  );

  hint_rec_datapath #(.CNT_W(CNT_W), .OCC_W(OCC_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .commitCount(commitCount), .sbOccupancy(sbOccupancy),
    .hintValid(hintValid), .hintCommit(hintCommit), .hintPending(hintPending)
  );

  // R4: own barrier request is always followed by a record
  a_r4_req_then_hint: assert property (@(posedge clk) disable iff (!rst_n)
    barrierReqOut |=> hintValid);

endmodule

// File: tb/test_hint_recorder.sv
module test_hint_recorder;

  localparam int LW = 16;
  localparam int CW = 32;
  localparam int OW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    trigMode = 2'd0;
  logic [LW-1:0] cycleLimit = '0, snoopLimit = '0, downLimit = '0;
  logic [CW-1:0] commitCount = '0;
  logic [OW-1:0] sbOccupancy = '0;
  logic          snoopPulse = 1'b0, downPulse = 1'b0, barrierReqIn = 1'b0;
  logic          barrierReqOut, hintValid;
  logic [CW-1:0] hintCommit;
  logic [OW-1:0] hintPending;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  hint_recorder i_hint_recorder (
    .clk(clk), .rst_n(rst_n), .trigMode(trigMode),
    .cycleLimit(cycleLimit), .snoopLimit(snoopLimit), .downLimit(downLimit),
    .commitCount(commitCount), .sbOccupancy(sbOccupancy),
    .snoopPulse(snoopPulse), .downPulse(downPulse),
    .barrierReqIn(barrierReqIn), .barrierReqOut(barrierReqOut),
    .hintValid(hintValid), .hintCommit(hintCommit), .hintPending(hintPending)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle of pulses, then sample at the following falling edge.
  task automatic cyc(input bit sp, input bit dp, input bit rr);
    snoopPulse = sp; downPulse = dp; barrierReqIn = rr;
    @(negedge clk);
    snoopPulse = 0; downPulse = 0; barrierReqIn = 0;
  endtask

  task automatic doReset();
    rst_n = 0;
    snoopPulse = 0; downPulse = 0; barrierReqIn = 0;
    repeat (2) @(negedge clk);
    chk("R1 hintValid in reset", hintValid, 0);
    chk("R1 barrierReqOut in reset", barrierReqOut, 0);
    rst_n = 1;
  endtask

  initial begin
    @(negedge clk);

    // R2 / R6 / R7 / R8: cycle mode sweep; remote request held high (ignored).
    // Occupancy is carried in a 6-bit field: value 32 is reported unchanged.
    for (int lim = 1; lim <= 6; lim++) begin
      int n;
      n = (lim == 1) ? 40 : 3 * lim;
      trigMode = 2'd0; cycleLimit = LW'(lim);
      doReset();
      for (int k = 1; k <= n; k++) begin
        commitCount = CW'(100 + k);
        sbOccupancy = OW'(k % 33);
        cyc(0, 0, 1);
        chk("R2 cycle hint timing", hintValid, (k % lim) == 0);
        chk("R6 no request in cycle mode", barrierReqOut, 0);
        if (hintValid) begin
          chk("R7 commit snapshot", hintCommit, 100 + k);
          if (k == 32) chk("R8 full buffer no wrap", hintPending, 32);
          else         chk("R8 occupancy snapshot", hintPending, k % 33);
        end
      end
    end

    // R3 / R6: broadcast mode sweep, limit means "exceeds".
    for (int s = 0; s <= 4; s++) begin
      trigMode = 2'd1; snoopLimit = LW'(s); cycleLimit = LW'(1);
      doReset();
      for (int p = 1; p <= 2 * (s + 1); p++) begin
        cyc(1, 0, 0);
        chk("R3 snoop hint timing", hintValid, (p % (s + 1)) == 0);
        cyc(0, 1, 1);
        chk("R6 remote ignored in broadcast mode", hintValid, 0);
        chk("R3 no request in broadcast mode", barrierReqOut, 0);
      end
    end

    // R4: downgrade mode sweep, two rounds to confirm the count restarts.
    for (int d = 0; d <= 3; d++) begin
      trigMode = 2'd2; downLimit = LW'(d); cycleLimit = LW'(1);
      doReset();
      for (int round = 0; round < 2; round++) begin
        for (int p = 1; p <= d + 1; p++) begin
          cyc(0, 1, 0);
          chk("R4 request timing", barrierReqOut, p == d + 1);
          chk("R4 no early hint", hintValid, 0);
        end
        cyc(0, 0, 0);
        chk("R4 request one cycle", barrierReqOut, 0);
        chk("R4 hint after request", hintValid, 1);
        cyc(0, 0, 0);
        chk("R6 cycle limit ignored in mode 2", hintValid, 0);
      end
    end

    // R5 / R11: remote request clears count; pulse in closing cycle dropped.
    trigMode = 2'd2; downLimit = LW'(2);
    doReset();
    cyc(0, 1, 0); cyc(0, 1, 0);
    chk("R5 below limit", barrierReqOut, 0);
    cyc(0, 0, 1);
    chk("R5 remote gives hint", hintValid, 1);
    chk("R5 remote gives no request", barrierReqOut, 0);
    cyc(0, 1, 0); cyc(0, 1, 0);
    chk("R5 count cleared by remote", barrierReqOut, 0);
    cyc(0, 1, 0);
    chk("R4 request after limit", barrierReqOut, 1);
    cyc(0, 1, 0);
    chk("R11 closing hint", hintValid, 1);
    cyc(0, 1, 0);
    cyc(0, 1, 0);
    chk("R11 pulse in closing cycle not counted", barrierReqOut, 0);
    cyc(0, 1, 0);
    chk("R11 request after fresh count", barrierReqOut, 1);
    cyc(0, 0, 0);
    chk("R11 hint", hintValid, 1);

    // R10: local trigger and remote request together.
    trigMode = 2'd2; downLimit = LW'(0);
    doReset();
    cyc(0, 1, 1);
    chk("R10 single hint", hintValid, 1);
    chk("R10 no request", barrierReqOut, 0);
    cyc(0, 0, 0);
    chk("R10 no second hint", hintValid, 0);
    chk("R10 still no request", barrierReqOut, 0);

    // R9: combined mode, cycle limit 5, downgrade limit 1.
    // Pulses at c=0,1,5,9: request at c=1, hints at c=2, 7, 12.
    trigMode = 2'd3; cycleLimit = LW'(5); downLimit = LW'(1);
    doReset();
    for (int c = 0; c <= 12; c++) begin
      cyc(0, (c == 0 || c == 1 || c == 5 || c == 9), 0);
      chk("R9 combined hint timing", hintValid, (c == 2 || c == 7 || c == 12));
      chk("R9 combined request timing", barrierReqOut, c == 1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule